// File: doc/BRIEF.md
# Up-Counting PWM Timer with Shadowed Period and Compare

The block is a single-channel up-counting timer. A write port loads a control word, a period (auto-reload) value and a compare value, and clears interrupt flags. The counter runs from zero up to the active period value and then returns to zero. The output pin drops on that wrap and rises again after the counter has matched the active compare value. This gives a pulse-width-modulated waveform whose period and duty can both be retuned while the counter is running.

The period and the compare value each sit behind a shadow register, and each has its own preload-enable bit. With preload off, a write changes the live value at once. With preload on, the write lands in the shadow and is copied to the live value only on an update event. An update event is a counter wrap while the update-disable bit is clear. Software can therefore load the values for the next period at any point in the current one. Two sticky flags, one for overflow and one for compare match, each drive an interrupt line through their own enable bit.

Top module: `pwm_shadow_timer`

## Requirements
- R1: After reset, `count` is 0. On each clock it goes up by 1 until it equals the active period value, and on the clock after that it is 0.
- R2: When `count` equals the active compare value, a compare-match event sets the compare flag. The flag is reported on `cmp_irq` when the flag's enable bit is set.
- R3: `pwm_out` is 0 from the clock after a wrap. It is 1 from the clock after a compare match. When the wrap and the match happen in the same cycle, the wrap wins.
- R4: The compare register is at `wr_addr` 2. With control bit 1 (compare preload) clear, a write takes effect on the next clock. With bit 1 set, the write goes to a shadow and becomes active only at an update event.
- R5: The period register is at `wr_addr` 1. With control bit 0 (period preload) clear, a write takes effect on the next clock. With bit 0 set, the write is held in its shadow until an update event.
- R6: An update event occurs on a wrap only while control bit 2 (update disable) is 0. While bit 2 is 1, shadowed values never reach the active registers.
- R7: The overflow flag is set on every wrap and the compare flag on every match, and each stays set until cleared. A write to `wr_addr` 3 clears the overflow flag where data bit 0 is 1 and the compare flag where data bit 1 is 1. If a flag is set and cleared in the same cycle, the set wins. `ovf_irq` is the overflow flag gated by control bit 3, and `cmp_irq` is the compare flag gated by control bit 4. The control word is at `wr_addr` 0.
- R8: If the active compare value is greater than the active period value, no match occurs. `pwm_out` then stays 0 for the whole period.
- R9: With preload enabled, a write to a shadow in the same cycle as an update event is captured, and the new value becomes active at that same event.
- R10: Reset state: `count` is 0 and `pwm_out` is 1. Both preloads, update disable and both interrupt enables are off. The active period is all ones, the active compare value is 0, and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 period, 2 compare, 3 flag clear |
| wr_data | input | CNT_W | Write data |
| count | output | CNT_W | Current counter value |
| pwm_out | output | 1 | PWM output pin |
| ovf_irq | output | 1 | Overflow interrupt (flag and enable) |
| cmp_irq | output | 1 | Compare interrupt (flag and enable) |

## Verification
The hold properties on the active registers assume that every write to the period or compare register while its preload bit is set goes only to the shadow. They also assume that the control word read in the write cycle is the one that applies to that write. The stimulus only changes the control word in a cycle of its own, separate from data writes. When it makes an immediate period write that lowers the period, it first waits until the counter is near zero. This keeps the counter from running past the new limit to the full 16-bit rollover. The same-cycle capture case is aimed by waiting until `count` equals the known period value and then writing in that cycle.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_CTRL    = 2'd0,
        REG_PERIOD  = 2'd1,
        REG_COMPARE = 2'd2,
        REG_FLAGS   = 2'd3
    } tmr_reg_e;

    // bit 0 period preload, bit 1 compare preload, bit 2 update disable,
    // bit 3 overflow irq enable, bit 4 compare irq enable
    typedef struct packed {
        logic cmp_ie;
        logic ovf_ie;
        logic upd_dis;
        logic cmp_pre;
        logic arr_pre;
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);

    typedef struct packed {
        logic cmp;
        logic ovf;
    } tmr_flags_t;

    function automatic logic reg_hit(input logic en,
                                     input logic [REG_ADDR_W-1:0] addr,
                                     input tmr_reg_e which);
        return en && (tmr_reg_e'(addr) == which);
    endfunction

endpackage

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] arr_act,
    input  logic [CNT_W-1:0] cmp_act,
    output logic [CNT_W-1:0] count,
    output logic             wrap,
    output logic             match
);

    always_comb begin
        wrap  = (count == arr_act);
        match = (count == cmp_act);
    end

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (wrap)
            count <= '0;
        else
            count <= count + CNT_W'(1);
    end

endmodule

// File: rtl/pwm_tmr_shadow.sv
module pwm_tmr_shadow #(
    parameter int           W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         pre_en,
    input  logic         uev,
    output logic [W-1:0] act
);

    logic [W-1:0] shadow;
    logic [W-1:0] shadow_next;

    // a write in the update cycle is forwarded so it lands at that event
    always_comb shadow_next = wr ? wr_data : shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= RST_VAL;
            act    <= RST_VAL;
        end else begin
            shadow <= shadow_next;
            if (wr && !pre_en)
                act <= wr_data;
            else if (uev && pre_en)
                act <= shadow_next;
        end
    end

endmodule

// File: rtl/pwm_tmr_out.sv
module pwm_tmr_out
    import pwm_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wrap,
    input  logic       match,
    input  tmr_flags_t clr,
    input  tmr_ctrl_t  ctrl,
    output logic       pwm_out,
    output logic       ovf_irq,
    output logic       cmp_irq
);

    tmr_flags_t flags;
    tmr_flags_t set;

    always_comb begin
        set.ovf = wrap;
        set.cmp = match;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            pwm_out <= 1'b1;
        end else begin
            flags <= (flags & ~clr) | set;
            if (wrap)
                pwm_out <= 1'b0;
            else if (match)
                pwm_out <= 1'b1;
        end
    end

    always_comb begin
        ovf_irq = flags.ovf & ctrl.ovf_ie;
        cmp_irq = flags.cmp & ctrl.cmp_ie;
    end

endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]      wr_data,
    output logic [CNT_W-1:0]      count,
    output logic                  pwm_out,
    output logic                  ovf_irq,
    output logic                  cmp_irq
);

    localparam int N_SHADOW = 2;
    localparam logic [CNT_W-1:0] ARR_RST = '1;
    localparam logic [CNT_W-1:0] CMP_RST = '0;

    tmr_ctrl_t        ctrl;
    tmr_flags_t       clr;
    logic             wr_ctrl;
    logic             wrap;
    logic             match;
    logic             uev;
    logic [CNT_W-1:0] arr_act;
    logic [CNT_W-1:0] cmp_act;

    logic [N_SHADOW-1:0]            sh_wr;
    logic [N_SHADOW-1:0]            sh_pre;
    logic [N_SHADOW-1:0][CNT_W-1:0] sh_act;

    always_comb begin
        wr_ctrl = reg_hit(wr_en, wr_addr, REG_CTRL);
        sh_wr   = {reg_hit(wr_en, wr_addr, REG_COMPARE),
                   reg_hit(wr_en, wr_addr, REG_PERIOD)};
        sh_pre  = {ctrl.cmp_pre, ctrl.arr_pre};
        clr     = reg_hit(wr_en, wr_addr, REG_FLAGS) ?
                  tmr_flags_t'(wr_data[1:0]) : '0;
        uev     = wrap & ~ctrl.upd_dis;
        arr_act = sh_act[0];
        cmp_act = sh_act[1];
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (wr_ctrl)
            ctrl <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    for (genvar i = 0; i < N_SHADOW; i++) begin : g_shadow
        pwm_tmr_shadow #(
            .W       (CNT_W),
            .RST_VAL ((i == 0) ? ARR_RST : CMP_RST)
        ) u_shadow (
            .clk     (clk),
            .rst     (rst),
            .wr      (sh_wr[i]),
            .wr_data (wr_data),
            .pre_en  (sh_pre[i]),
            .uev     (uev),
            .act     (sh_act[i])
        );
    end

    pwm_tmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .arr_act (arr_act),
        .cmp_act (cmp_act),
        .count   (count),
        .wrap    (wrap),
        .match   (match)
    );

    pwm_tmr_out u_out (
        .clk     (clk),
        .rst     (rst),
        .wrap    (wrap),
        .match   (match),
        .clr     (clr),
        .ctrl    (ctrl),
        .pwm_out (pwm_out),
        .ovf_irq (ovf_irq),
        .cmp_irq (cmp_irq)
    );

endmodule

// File: rtl/pwm_shadow_timer_chk.sv
module pwm_shadow_timer_chk
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count,
    input logic             pwm_out,
    input logic             ovf_irq,
    input logic             cmp_irq,
    input logic [CNT_W-1:0] arr_act,
    input logic [CNT_W-1:0] cmp_act,
    input tmr_ctrl_t        ctrl,
    input tmr_flags_t       clr,
    input logic             wr_ctrl,
    input logic             uev
);

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (count != arr_act) |=> (count == CNT_W'($past(count) + CNT_W'(1))));

    // R1
    count_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (count == arr_act) |=> (count == '0));

    // R3
    pwm_low_chk: assert property (@(posedge clk) disable iff (rst)
        (count == arr_act) |=> !pwm_out);

    // R3
    pwm_high_chk: assert property (@(posedge clk) disable iff (rst)
        (count == cmp_act && count != arr_act) |=> pwm_out);

    // R4
    cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.cmp_pre && !uev) |=> $stable(cmp_act));

    // R5
    arr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.arr_pre && !uev) |=> $stable(arr_act));

    // R6
    no_update_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.upd_dis && ctrl.arr_pre && ctrl.cmp_pre)
        |=> ($stable(arr_act) && $stable(cmp_act)));

    // R7
    ovf_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.ovf_ie |-> !ovf_irq);

    // R7
    cmp_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.cmp_ie |-> !cmp_irq);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_irq && !clr.ovf && !wr_ctrl) |=> ovf_irq);

    // R2
    cmp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_irq && !clr.cmp && !wr_ctrl) |=> cmp_irq);

endmodule

bind pwm_shadow_timer pwm_shadow_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .count   (count),
    .pwm_out (pwm_out),
    .ovf_irq (ovf_irq),
    .cmp_irq (cmp_irq),
    .arr_act (arr_act),
    .cmp_act (cmp_act),
    .ctrl    (ctrl),
    .clr     (clr),
    .wr_ctrl (wr_ctrl),
    .uev     (uev)
);

// File: tb/tb_pwm_shadow_timer.sv
module tb_pwm_shadow_timer;
    import pwm_timer_pkg::*;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] count;
    logic         pwm_out, ovf_irq, cmp_irq;

    always #4 clk = ~clk;

    pwm_shadow_timer #(.CNT_W(W)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .pwm_out(pwm_out),
        .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
    );

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pwm;
        logic         oirq;
        logic         cirq;
    } exp_t;

    exp_t  exp_q[$];
    int    checks = 0;
    int    fails  = 0;
    string scen   = "R10";
    bit    done   = 1'b0;

    // requirement-level model, advanced on each rising edge
    logic [W-1:0] m_cnt, m_arr, m_cmp, m_arr_sh, m_cmp_sh, arr_n, cmp_n;
    logic         m_pwm, m_of, m_cf, wrap, match, uev;
    logic [4:0]   m_ctrl;

    always @(posedge clk) begin
        if (rst) begin
            // R10 reset values
            m_cnt = '0; m_arr = '1; m_cmp = '0; m_arr_sh = '1; m_cmp_sh = '0;
            m_pwm = 1'b1; m_of = 1'b0; m_cf = 1'b0; m_ctrl = '0;
        end else begin
            wrap  = (m_cnt == m_arr);
            match = (m_cnt == m_cmp);
            uev   = wrap && !m_ctrl[2];                      // R6
            m_cnt = wrap ? '0 : m_cnt + 16'd1;               // R1
            if (wrap) m_pwm = 1'b0; else if (match) m_pwm = 1'b1;   // R3
            if (wr_en && wr_addr == 2'd3) begin
                if (wr_data[0]) m_of = 1'b0;
                if (wr_data[1]) m_cf = 1'b0;
            end
            if (wrap)  m_of = 1'b1;                          // R7
            if (match) m_cf = 1'b1;                          // R2
            arr_n = (wr_en && wr_addr == 2'd1) ? wr_data : m_arr_sh;  // R9
            cmp_n = (wr_en && wr_addr == 2'd2) ? wr_data : m_cmp_sh;
            if (wr_en && wr_addr == 2'd1 && !m_ctrl[0]) m_arr = wr_data;      // R5
            else if (uev && m_ctrl[0]) m_arr = arr_n;
            if (wr_en && wr_addr == 2'd2 && !m_ctrl[1]) m_cmp = wr_data;      // R4
            else if (uev && m_ctrl[1]) m_cmp = cmp_n;
            m_arr_sh = arr_n;
            m_cmp_sh = cmp_n;
            if (wr_en && wr_addr == 2'd0) m_ctrl = wr_data[4:0];
        end
        exp_q.push_back({m_cnt, m_pwm, m_of & m_ctrl[3], m_cf & m_ctrl[4]});
    end

    // monitor: pops expectations away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks += 4;
            if (count !== e.cnt) begin
                fails++;
                $display("FAIL R1 count [%s] actual %0d expected %0d", scen, count, e.cnt);
            end
            if (pwm_out !== e.pwm) begin
                fails++;
                $display("FAIL R3 pwm_out [%s] actual %0b expected %0b", scen, pwm_out, e.pwm);
            end
            if (ovf_irq !== e.oirq) begin
                fails++;
                $display("FAIL R7 ovf_irq [%s] actual %0b expected %0b", scen, ovf_irq, e.oirq);
            end
            if (cmp_irq !== e.cirq) begin
                fails++;
                $display("FAIL R2 cmp_irq [%s] actual %0b expected %0b", scen, cmp_irq, e.cirq);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 2'd0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_count(input logic [W-1:0] v);
        do @(negedge clk); while (count != v);
    endtask

    initial begin
        // R10: reset held, then released
        idle(3);
        rst = 1'b0;
        idle(2);

        // R1 / R3: immediate period 9, compare 3
        scen = "R1";
        wr(2'd1, 16'd9);
        wr(2'd2, 16'd3);
        idle(30);

        // R4: immediate compare change mid-period
        scen = "R4";
        wr(2'd2, 16'd6);
        idle(25);
        wr(2'd0, 16'b00010);             // compare preload on
        wr(2'd2, 16'd2);
        idle(25);

        // R5: period preload on, shadowed change, then immediate increase
        scen = "R5";
        wr(2'd0, 16'b00011);
        wr(2'd1, 16'd5);
        idle(25);
        wr(2'd0, 16'b00010);
        wr(2'd1, 16'd12);
        idle(30);

        // R6: update disabled holds shadows, then re-enabled
        scen = "R6";
        wr(2'd0, 16'b00111);
        wr(2'd2, 16'd4);
        wr(2'd1, 16'd7);
        idle(40);
        wr(2'd0, 16'b00011);
        idle(30);

        // R9: shadow write in the very cycle of the update event
        scen = "R9";
        wait_count(16'd7);
        wr(2'd2, 16'd1);
        idle(20);
        wait_count(16'd7);
        wr(2'd1, 16'd10);
        idle(30);

        // R8: compare beyond period, immediate mode
        scen = "R8";
        wr(2'd0, 16'b00000);
        wait_count(16'd1);
        wr(2'd1, 16'd7);
        wr(2'd2, 16'd20);
        idle(25);

        // R7: enables, write-1-to-clear, masking
        scen = "R7";
        wr(2'd2, 16'd3);
        wr(2'd0, 16'b11000);
        idle(6);
        wr(2'd3, 16'd1);
        idle(3);
        wr(2'd3, 16'd2);
        idle(12);
        wait_count(16'd7);               // clear in the wrap cycle: set wins
        wr(2'd3, 16'd3);
        idle(4);
        wr(2'd0, 16'b01000);
        idle(12);
        wr(2'd0, 16'b00000);
        idle(10);

        // R10: reset again mid-run
        scen = "R10";
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(6);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog [%s] actual running expected finished", scen);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule